// File: doc/BRIEF.md
# Framed Packet CRC Verdict Checker

This block watches a stream of descrambled symbols, one per clock when qualified by a valid input. Each symbol has a two-bit kind tag and a data byte. A packet opens with a start symbol, carries a fixed number of data symbols, and closes with an end symbol. The last two data symbols hold a 16-bit CRC of the data symbols before them.

For every end symbol that closes an open packet, the block raises a one-cycle verdict strobe together with an error flag. The error flag is fail-safe. It stays high all the time and drops only in the verdict cycle of a packet whose length and CRC both check out. A stalled, truncated or interrupted packet therefore can never look good to the packet decoders that sit downstream.

Top module: `pkt_crc_checker`

## Requirements
- R1: After a synchronous active-low reset, `verdict_vld` is 0 and `pkt_error` is 1.
- R2: Kind codes are 2'b01 start, 2'b10 data and 2'b11 end. A packet of exactly `DATA_LEN` data symbols whose final two bytes equal, high byte first, the CRC of the preceding bytes produces `verdict_vld`=1 and `pkt_error`=0 in the cycle after the end symbol is accepted. The CRC uses polynomial 0x1021, seed 0xFFFF, and takes each byte MSB first with no final XOR.
- R3: A packet with the right length but a CRC that differs from the computed value gives a verdict with `pkt_error`=1.
- R4: An end symbol that arrives after fewer or more than `DATA_LEN` data symbols gives a verdict with `pkt_error`=1.
- R5: A start symbol inside an open packet discards that packet without any verdict, and restarts the count and the CRC, so the new packet is judged on its own.
- R6: Data and end symbols that arrive while no packet is open are ignored. They produce no verdict and do not disturb the next packet.
- R7: Each end symbol that closes an open packet gives exactly one verdict strobe, and that strobe lasts one cycle.
- R8: `pkt_error` is 1 in every cycle except the verdict cycle of a good packet.
- R9: Cycles with `sym_valid`=0, and symbols with kind 2'b00, have no effect, so gaps inside a packet do not change its verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Qualifies the symbol on this cycle |
| sym_kind | input | 2 | Symbol kind tag |
| sym_data | input | 8 | Symbol data byte |
| verdict_vld | output | 1 | One-cycle strobe after a packet-closing end symbol |
| pkt_error | output | 1 | Fail-safe error flag; low only on a good verdict |

## Verification
The verdict register of one packet updates in the same cycle that the start symbol of the next packet resets the counter and the CRC seed. The bench provokes this by sending packets back to back with no idle cycle between an end symbol and the next start. The scoreboard then requires two verdicts, each matching its own packet, and neither verdict may be affected by the restart that shares its cycle.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;
  typedef enum logic [1:0] {
    SYM_NONE = 2'b00,
    SYM_SOP  = 2'b01,
    SYM_DATA = 2'b10,
    SYM_EOP  = 2'b11
  } sym_kind_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // one byte through the CRC register, MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/pkt_frame_tracker.sv
module pkt_frame_tracker
  import pkt_crc_pkg::*;
#(
  parameter int DATA_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sym_valid,
  input  logic [1:0]  sym_kind,
  input  logic [7:0]  sym_data,
  output logic        sop_hit,
  output logic        eop_hit,
  output logic        len_ok,
  output logic        feed_vld,
  output logic [7:0]  feed_byte,
  output logic [15:0] tail_word
);
  localparam int CNT_W = $clog2(DATA_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_LEN + 1);

  logic             in_pkt;
  logic [CNT_W-1:0] count;
  logic [7:0]       hold_old, hold_new;
  logic             data_hit, stray_data;

  assign sop_hit    = sym_valid && (sym_kind == SYM_SOP);
  assign data_hit   = sym_valid && (sym_kind == SYM_DATA) && in_pkt;
  assign eop_hit    = sym_valid && (sym_kind == SYM_EOP) && in_pkt;
  assign stray_data = sym_valid && (sym_kind == SYM_DATA) && !in_pkt;
  assign len_ok     = (count == CNT_W'(DATA_LEN));
  // the byte leaving the two-byte tail window is payload
  assign feed_vld   = data_hit && (count >= CNT_W'(2));
  assign feed_byte  = hold_old;
  assign tail_word  = {hold_old, hold_new};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      count    <= '0;
      hold_old <= '0;
      hold_new <= '0;
    end else if (sop_hit) begin
      in_pkt   <= 1'b1;
      count    <= '0;
      hold_old <= '0;
      hold_new <= '0;
    end else if (data_hit) begin
      hold_new <= sym_data;
      hold_old <= hold_new;
      if (count != CNT_MAX) count <= count + 1'b1;
    end else if (eop_hit) begin
      in_pkt <= 1'b0;
    end
  end

  p_sop_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sop_hit |=> (in_pkt && count == '0));
  p_stray_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stray_data |=> (!in_pkt && $stable(count)));
  p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);
endmodule

// File: rtl/pkt_crc_accum.sv
module pkt_crc_accum
  import pkt_crc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        feed_vld,
  input  logic [7:0]  feed_byte,
  output logic [15:0] crc_now
);
  always_ff @(posedge clk) begin
    if (!rst_n || restart) crc_now <= CRC_SEED;
    else if (feed_vld)     crc_now <= crc16_step(crc_now, feed_byte);
  end

  p_crc_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (crc_now == CRC_SEED));
  p_crc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !feed_vld) |=> $stable(crc_now));
endmodule

// File: rtl/pkt_verdict_unit.sv
module pkt_verdict_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        eop_hit,
  input  logic        len_ok,
  input  logic [15:0] crc_now,
  input  logic [15:0] tail_word,
  output logic        verdict_vld,
  output logic        pkt_error
);
  logic pkt_good;
  assign pkt_good = eop_hit && len_ok && (crc_now == tail_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_vld <= 1'b0;
      pkt_error   <= 1'b1;
    end else begin
      verdict_vld <= eop_hit;
      pkt_error   <= !pkt_good;
    end
  end

  p_err_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_vld |-> pkt_error);
  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld);
  p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eop_hit |=> verdict_vld);
  p_bad_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_hit && !len_ok) |=> pkt_error);
endmodule

// File: rtl/pkt_crc_checker.sv
module pkt_crc_checker #(
  parameter int DATA_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_kind,
  input  logic [7:0] sym_data,
  output logic       verdict_vld,
  output logic       pkt_error
);
  logic        sop_hit, eop_hit, len_ok, feed_vld;
  logic [7:0]  feed_byte;
  logic [15:0] tail_word, crc_now;

  pkt_frame_tracker #(.DATA_LEN(DATA_LEN)) u_track (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_kind(sym_kind),
    .sym_data(sym_data), .sop_hit(sop_hit), .eop_hit(eop_hit), .len_ok(len_ok),
    .feed_vld(feed_vld), .feed_byte(feed_byte), .tail_word(tail_word)
  );

  pkt_crc_accum u_crc (
    .clk(clk), .rst_n(rst_n), .restart(sop_hit), .feed_vld(feed_vld),
    .feed_byte(feed_byte), .crc_now(crc_now)
  );

  pkt_verdict_unit u_verdict (
    .clk(clk), .rst_n(rst_n), .eop_hit(eop_hit), .len_ok(len_ok),
    .crc_now(crc_now), .tail_word(tail_word),
    .verdict_vld(verdict_vld), .pkt_error(pkt_error)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!verdict_vld && pkt_error));
endmodule

// File: tb/pkt_crc_checker_tb.sv
module pkt_crc_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLEN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym_kind = 2'b00;
  logic [7:0] sym_data = 8'h00;
  logic       verdict_vld, pkt_error;

  int checks = 0;
  int fails = 0;
  int r8_viol = 0;
  int prev_vld = 0;
  bit done = 0;
  bit exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_crc_checker #(.DATA_LEN(DLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_kind(sym_kind),
    .sym_data(sym_data), .verdict_vld(verdict_vld), .pkt_error(pkt_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference CRC written as left-aligned XOR form
  function automatic logic [15:0] ref_crc(input logic [7:0] b[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (b[k]) begin
      c = c ^ {b[k], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic sym(input logic [1:0] k, input logic [7:0] d);
    @(posedge clk); #1;
    sym_valid = 1'b1; sym_kind = k; sym_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sym_valid = 1'b0; sym_kind = 2'b00; sym_data = 8'hA5;
    end
  endtask

  // driver: builds a packet, pushes the expected error flag into the scoreboard
  task automatic send_pkt(input int nbytes, input logic [7:0] seed, input bit bad_crc, input bit gaps);
    logic [7:0] pl[$];
    logic [15:0] c;
    for (int i = 0; i < DLEN - 2; i++) pl.push_back(8'(seed + i * 37));
    c = ref_crc(pl);
    pl.push_back(c[15:8]);
    pl.push_back(c[7:0] ^ (bad_crc ? 8'h01 : 8'h00));
    while (pl.size() > nbytes) void'(pl.pop_back());
    while (pl.size() < nbytes) pl.push_back(8'h3C);
    exp_q.push_back(bad_crc || (nbytes != DLEN));
    sym(2'b01, 8'h00);
    foreach (pl[i]) begin
      sym(2'b10, pl[i]);
      if (gaps && i[0]) begin
        @(posedge clk); #1; sym_valid = 1'b0; sym_data = 8'hFF;
        @(posedge clk); #1; sym_valid = 1'b1; sym_kind = 2'b00; sym_data = 8'h11;
      end
    end
    sym(2'b11, 8'h00);
  endtask

  // monitor: pops expected verdicts as the design produces them
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!verdict_vld && !pkt_error) r8_viol++;
      if (verdict_vld && prev_vld != 0) check(0, "R7 double strobe", 1, 0);
      if (verdict_vld) begin
        if (exp_q.size() == 0) check(0, "R6/R5 unexpected verdict", 1, 0);
        else begin
          automatic bit e = exp_q.pop_front();
          check(pkt_error == e, "R2/R3/R4 verdict flag", int'(pkt_error), int'(e));
        end
      end
      prev_vld = int'(verdict_vld);
    end
  end

  task automatic drain(input string req);
    idle(3);
    @(negedge clk); #1;
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic finish_run;
    done = 1;
    check(r8_viol == 0, "R8 error flag default", r8_viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk);
    check(verdict_vld == 1'b0, "R1 strobe low", int'(verdict_vld), 0);
    check(pkt_error == 1'b1, "R1 error high", int'(pkt_error), 1);
    @(posedge clk); #1; rst_n = 1'b1;

    send_pkt(DLEN, 8'h10, 0, 0);  drain("R2 good packet");
    send_pkt(DLEN, 8'hC3, 0, 0);  drain("R2 second pattern");
    send_pkt(DLEN, 8'h55, 0, 1);  drain("R9 gaps and null symbols");
    send_pkt(DLEN, 8'h20, 1, 0);  drain("R3 crc mismatch");
    send_pkt(DLEN, 8'h20, 1, 1);  drain("R3 mismatch with gaps");
    send_pkt(DLEN - 1, 8'h40, 0, 0); drain("R4 short packet");
    send_pkt(DLEN + 1, 8'h40, 0, 0); drain("R4 long packet");

    // R5: abandoned packet followed by a fresh good one
    sym(2'b01, 8'h00); sym(2'b10, 8'h99); sym(2'b10, 8'h98); sym(2'b10, 8'h97);
    send_pkt(DLEN, 8'h77, 0, 0); drain("R5 restart on inner start");

    // R6: stray data and end while idle, then a good packet
    idle(2);
    sym(2'b10, 8'h12); sym(2'b11, 8'h00); sym(2'b10, 8'h34);
    drain("R6 stray symbols give no verdict");
    send_pkt(DLEN, 8'h01, 0, 0); drain("R6 packet after strays");

    // R7: back to back, verdict shares a cycle with the next start
    send_pkt(DLEN, 8'hA0, 0, 0);
    send_pkt(DLEN, 8'hB0, 1, 0);
    send_pkt(DLEN, 8'hE0, 0, 0);
    drain("R7 back to back verdicts");

    finish_run();
  end
endmodule